// File: doc/BRIEF.md
# Local Bus Memory Cycle Controller

This block turns single read or write requests from an internal requester into one cycle on an external 16-bit local bus. The external bus is asynchronous in style and serves RAM, ROM and an auxiliary device. The requester supplies an address, write data, byte enables, a direction and a target code, all with one request pulse. For writes, the block drives the address, the data, one chip select and two byte-lane write strobes. For reads, it drives the address, one chip select and the output enable. A ready input from the device adds wait states. At the end of the cycle the block returns a one-clock done pulse, and for reads it also returns the captured data.

The bus clock leaves the block at the system clock rate and in phase with it. Address, data and selects change only on rising edges. Write strobes open on a falling edge and close on a rising edge, so the device always sees its address, data and select settled before a strobe opens and still held after the strobe closes. The block accepts a request only while it is idle, and it leaves at least one clock between releasing the output enable and driving the data bus.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: `bus_clk_o` equals `clk_i`: high just after each rising edge and low just after each falling edge.
- R2: After the rising edge that accepts a request, `bus_addr_o` holds the address and exactly one active-low select is low: target 0 selects RAM, target 1 selects ROM, targets 2 and 3 select the auxiliary device. At no time is more than one select low.
- R3: A write drives `bus_data_o` with `bus_data_oe_o` high from the accept edge. Both strobes stay high through the next rising edge and open only on the falling edge after it.
- R4: Strobe bit 0 serves the lower byte lane and bit 1 the upper lane. Only the lanes whose `be_i` bit is 1 go low (active low).
- R5: The strobes close on the rising edge at which ready is sampled high. Address, data and select are held for one more clock after that edge.
- R6: Each rising edge that samples ready low during the strobe of a write, or during a read, adds one clock. The write strobe stays low through every added clock.
- R7: A read samples ready from the first rising edge after accept. On the edge where ready is high, the block captures `bus_data_i` into `rdata_o`, releases the output enable and the select, and raises done. A read with no wait states completes one clock after accept.
- R8: `bus_oe_no` goes low only in reads and `bus_data_oe_o` goes high only in writes. The two are never active together.
- R9: In the clock in which the output enable is released, `bus_data_oe_o` stays low.
- R10: `done_o` is one clock wide. It comes three clocks after accept for a write with no wait states. A request presented while a cycle runs is ignored and does not change the bus address.
- R11: While `rst_ni` is low, `bus_rst_no` is low, all selects, the output enable and both strobes are high, and drive and done are low. `bus_rst_no` rises on the first rising edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request pulse, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| tgt_i | input | 2 | Target: 0 RAM, 1 ROM, 2/3 auxiliary |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte-lane enables for writes |
| rdata_o | output | 16 | Captured read data |
| done_o | output | 1 | One-clock completion pulse |
| bus_clk_o | output | 1 | Bus clock |
| bus_rst_no | output | 1 | Bus reset, active low |
| bus_addr_o | output | 16 | Bus address |
| bus_data_o | output | 16 | Bus write data |
| bus_data_oe_o | output | 1 | Data bus drive enable |
| bus_data_i | input | 16 | Bus read data |
| bus_oe_no | output | 1 | Output enable, active low |
| bus_we_no | output | 2 | Byte-lane write strobes, active low |
| ram_cs_no | output | 1 | RAM select, active low |
| rom_cs_no | output | 1 | ROM select, active low |
| aux_cs_no | output | 1 | Auxiliary select, active low |
| bus_rdy_i | input | 1 | Device ready, sampled on rising edges |

## Verification
Two events can fall on neighbouring edges: a read ending, which releases the output enable, and a following write taking the data bus. The bench provokes this by presenting the write request in the middle of the read's done clock. It then checks at the ports that drive stays off while the output enable rises, and that drive comes on only from the next accept edge. A second collision happens when a request arrives while a write strobe is open. The bench raises the request with a different address during the strobe and judges that the bus address and the cycle timing do not change.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RDWAIT
  } cyc_state_e;
endpackage

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic rdy_i,
  output logic acc_o,
  output logic fin_o,
  output logic cap_o,
  output logic win_o,
  output logic done_o
);
  cyc_state_e st_q, st_d;
  logic done_q;

  always_comb begin
    st_d  = st_q;
    acc_o = 1'b0;
    fin_o = 1'b0;
    cap_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        acc_o = 1'b1;
        st_d  = we_i ? ST_SETUP : ST_RDWAIT;
      end
      ST_SETUP:  st_d = ST_STROBE;
      ST_STROBE: if (rdy_i) st_d = ST_HOLD;
      ST_HOLD: begin
        fin_o = 1'b1;
        st_d  = ST_IDLE;
      end
      ST_RDWAIT: if (rdy_i) begin
        fin_o = 1'b1;
        cap_o = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_o;
    end
  end

  assign win_o  = (st_q == ST_STROBE);
  assign done_o = done_q;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/lbus_strobe.sv
module lbus_strobe #(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] we_no
);
  logic arm_q;

  // arm on the falling edge inside the window; window closes on a rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= win_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign we_no[l] = ~(arm_q & win_i & be_i[l]);
  end

  p_arm_in_win_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |-> win_i);
endmodule

// File: rtl/lbus_datapath.sv
module lbus_datapath #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int TW      = 2,
  parameter int NUM_SEL = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic               fin_i,
  input  logic               cap_i,
  input  logic               we_i,
  input  logic [TW-1:0]      tgt_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW/8-1:0]    be_i,
  input  logic [DW-1:0]      bus_data_i,
  output logic [AW-1:0]      addr_o,
  output logic [DW-1:0]      data_o,
  output logic               drive_o,
  output logic               oe_no,
  output logic [NUM_SEL-1:0] cs_no,
  output logic [DW/8-1:0]    be_o,
  output logic [DW-1:0]      rdata_o
);
  localparam logic [TW-1:0] LAST_SEL = TW'(NUM_SEL - 1);

  logic              cyc_q, wr_q;
  logic [TW-1:0]     tgt_q, sel_idx;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q, rdata_q;
  logic [DW/8-1:0]   be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= 1'b0;
      wr_q    <= 1'b0;
      tgt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (acc_i) begin
        cyc_q   <= 1'b1;
        wr_q    <= we_i;
        tgt_q   <= tgt_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end else if (fin_i) begin
        cyc_q <= 1'b0;
      end
      if (cap_i) rdata_q <= bus_data_i;
    end
  end

  // codes above the last select fold onto it
  assign sel_idx = (tgt_q > LAST_SEL) ? LAST_SEL : tgt_q;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign cs_no[g] = ~(cyc_q && (sel_idx == TW'(g)));
  end

  assign addr_o  = addr_q;
  assign data_o  = wdata_q;
  assign be_o    = be_q;
  assign drive_o = cyc_q & wr_q;
  assign oe_no   = ~(cyc_q & ~wr_q);
  assign rdata_o = rdata_q;

  p_one_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);
  p_no_fight_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && drive_o));
  p_turn_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_no) |-> !drive_o);
endmodule

// File: rtl/lbus_cycle_ctrl.sv
module lbus_cycle_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [TW-1:0]     tgt_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW/8-1:0]   be_i,
  output logic [DW-1:0]     rdata_o,
  output logic              done_o,
  output logic              bus_clk_o,
  output logic              bus_rst_no,
  output logic [AW-1:0]     bus_addr_o,
  output logic [DW-1:0]     bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DW-1:0]     bus_data_i,
  output logic              bus_oe_no,
  output logic [DW/8-1:0]   bus_we_no,
  output logic              ram_cs_no,
  output logic              rom_cs_no,
  output logic              aux_cs_no,
  input  logic              bus_rdy_i
);
  localparam int LANES   = DW / 8;
  localparam int NUM_SEL = 3;

  logic acc, fin, cap, win, brst_q;
  logic [LANES-1:0]   be_q;
  logic [NUM_SEL-1:0] cs_n;

  lbus_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .rdy_i  (bus_rdy_i),
    .acc_o  (acc),
    .fin_o  (fin),
    .cap_o  (cap),
    .win_o  (win),
    .done_o (done_o)
  );

  lbus_datapath #(.AW(AW), .DW(DW), .TW(TW), .NUM_SEL(NUM_SEL)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .fin_i      (fin),
    .cap_i      (cap),
    .we_i       (we_i),
    .tgt_i      (tgt_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .be_i       (be_i),
    .bus_data_i (bus_data_i),
    .addr_o     (bus_addr_o),
    .data_o     (bus_data_o),
    .drive_o    (bus_data_oe_o),
    .oe_no      (bus_oe_no),
    .cs_no      (cs_n),
    .be_o       (be_q),
    .rdata_o    (rdata_o)
  );

  lbus_strobe #(.LANES(LANES)) u_stb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .win_i  (win),
    .be_i   (be_q),
    .we_no  (bus_we_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brst_q <= 1'b0;
    else         brst_q <= 1'b1;
  end

  assign bus_clk_o  = clk_i;
  assign bus_rst_no = brst_q;
  assign ram_cs_no  = cs_n[0];
  assign rom_cs_no  = cs_n[1];
  assign aux_cs_no  = cs_n[2];

  p_we_needs_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_no != '1) |-> (bus_data_oe_o && (cs_n != '1)));
  p_hold_after_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_no != '1) |=> ($stable(bus_addr_o) && (cs_n != '1)));
endmodule

// File: tb/sim_lbus_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_lbus_cycle_ctrl;
  typedef struct packed {
    logic        we;
    logic [1:0]  tgt;
    logic [15:0] addr;
    logic [15:0] wd;
    logic [1:0]  be;
    logic [2:0]  ws;
    logic [15:0] rsp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 16'h1234, 16'hA5A5, 2'b11, 3'd0, 16'h0000},
    '{1'b0, 2'd1, 16'h8000, 16'h0000, 2'b00, 3'd0, 16'hBEEF},
    '{1'b1, 2'd2, 16'h00F0, 16'h5A5A, 2'b01, 3'd2, 16'h0000},
    '{1'b0, 2'd0, 16'hFFFE, 16'h0000, 2'b00, 3'd3, 16'hC0DE},
    '{1'b1, 2'd1, 16'h4321, 16'h0F0F, 2'b10, 3'd1, 16'h0000},
    '{1'b0, 2'd3, 16'h0101, 16'h0000, 2'b00, 3'd1, 16'h7E57},
    '{1'b1, 2'd3, 16'h2222, 16'h1111, 2'b00, 3'd0, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, rdy = 1'b0;
  logic [1:0]  tgt = '0, be = '0;
  logic [15:0] addr = '0, wd = '0, bdi = '0;
  logic [15:0] rdata, baddr, bdo;
  logic done, bclk, brst_n, bdoe, boe_n, ram_n, rom_n, aux_n;
  logic [1:0] bwe_n;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  lbus_cycle_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .tgt_i(tgt),
    .addr_i(addr), .wdata_i(wd), .be_i(be), .rdata_o(rdata), .done_o(done),
    .bus_clk_o(bclk), .bus_rst_no(brst_n), .bus_addr_o(baddr),
    .bus_data_o(bdo), .bus_data_oe_o(bdoe), .bus_data_i(bdi),
    .bus_oe_no(boe_n), .bus_we_no(bwe_n), .ram_cs_no(ram_n),
    .rom_cs_no(rom_n), .aux_cs_no(aux_n), .bus_rdy_i(rdy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] cs_exp(input logic [1:0] t);
    case (t)
      2'd0:    return 3'b110;
      2'd1:    return 3'b101;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [2:0] cs_now();
    return {aux_n, rom_n, ram_n};
  endfunction

  // caller is just after a falling edge; returns just after a falling edge
  task automatic do_write(input vec_t v, input bit poke);
    req = 1; we = 1; tgt = v.tgt; addr = v.addr; wd = v.wd; be = v.be;
    rdy = (v.ws == 0);
    @(posedge clk); #1;
    chk(done == 0, "R10 done low at accept", done, 0);
    chk(baddr == v.addr, "R2 address", baddr, v.addr);
    chk(cs_now() == cs_exp(v.tgt), "R2 select", cs_now(), cs_exp(v.tgt));
    chk(bdoe && bdo == v.wd, "R3 write data driven", {bdoe, bdo}, {1'b1, v.wd});
    chk(boe_n == 1, "R8 no oe on write", boe_n, 1);
    chk(bwe_n == 2'b11, "R3 strobes closed at accept", bwe_n, 2'b11);
    @(negedge clk);
    req = poke;
    if (poke) addr = ~v.addr;
    @(posedge clk); #1;
    chk(bwe_n == 2'b11, "R3 strobe waits for falling edge", bwe_n, 2'b11);
    @(negedge clk);
    req = 0;
    #1;
    chk(bwe_n == ~v.be, "R4 lane strobes", bwe_n, ~v.be);
    if (poke) chk(baddr == v.addr, "R10 busy request ignored", baddr, v.addr);
    for (int k = 0; k < int'(v.ws); k++) begin
      @(posedge clk); #1;
      chk(bwe_n == ~v.be, "R6 strobe stretched", bwe_n, ~v.be);
      chk(done == 0, "R6 no done while waiting", done, 0);
      @(negedge clk);
      if (k == int'(v.ws) - 1) rdy = 1;
    end
    @(posedge clk); #1;
    chk(bwe_n == 2'b11, "R5 strobe closed on ready edge", bwe_n, 2'b11);
    chk(baddr == v.addr && cs_now() == cs_exp(v.tgt) && bdoe,
        "R5 hold after strobe", {bdoe, cs_now(), baddr}, {1'b1, cs_exp(v.tgt), v.addr});
    @(posedge clk); #1;
    chk(done == 1, "R10 write done", done, 1);
    chk(cs_now() == 3'b111 && !bdoe, "R5 release after hold", {bdoe, cs_now()}, 4'b0111);
    @(posedge clk); #1;
    chk(done == 0, "R10 done one clock", done, 0);
    chk(baddr == v.addr, "R10 no new cycle", baddr, v.addr);
    @(negedge clk);
  endtask

  task automatic do_read(input vec_t v);
    req = 1; we = 0; tgt = v.tgt; addr = v.addr; bdi = v.rsp;
    rdy = (v.ws == 0);
    @(posedge clk); #1;
    chk(done == 0, "R10 done low at accept", done, 0);
    chk(baddr == v.addr, "R2 read address", baddr, v.addr);
    chk(cs_now() == cs_exp(v.tgt), "R2 read select", cs_now(), cs_exp(v.tgt));
    chk(boe_n == 0 && !bdoe, "R8 read oe, no drive", {boe_n, bdoe}, 2'b00);
    @(negedge clk);
    req = 0;
    for (int k = 0; k < int'(v.ws); k++) begin
      @(posedge clk); #1;
      chk(boe_n == 0 && done == 0, "R6 read wait", {boe_n, done}, 2'b00);
      @(negedge clk);
      if (k == int'(v.ws) - 1) rdy = 1;
    end
    @(posedge clk); #1;
    chk(done == 1, "R7 read done", done, 1);
    chk(rdata == v.rsp, "R7 read data", rdata, v.rsp);
    chk(boe_n == 1 && cs_now() == 3'b111, "R7 oe and select released", {boe_n, cs_now()}, 4'hF);
    chk(!bdoe, "R9 no drive at oe release", bdoe, 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk(brst_n == 0 && ram_n && rom_n && aux_n && boe_n && bwe_n == 2'b11 && !bdoe && !done,
        "R11 reset state", {brst_n, ram_n, rom_n, aux_n, boe_n, bwe_n, bdoe, done}, 9'b011111100);
    #10;
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk(brst_n == 1, "R11 bus reset released", brst_n, 1);
    chk(bclk == 1, "R1 bus clock high", bclk, 1);
    @(negedge clk); #1;
    chk(bclk == 0, "R1 bus clock low", bclk, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) do_write(VEC[i], 1'b0);
      else           do_read(VEC[i]);
    end

    // read then write presented in the done clock (R9 turnaround)
    do_read('{1'b0, 2'd2, 16'h3030, 16'h0, 2'b00, 3'd0, 16'h9999});
    do_write('{1'b1, 2'd0, 16'h3032, 16'h6666, 2'b11, 3'd1, 16'h0}, 1'b1);

    // reset in mid-strobe (R11)
    req = 1; we = 1; tgt = 2'd1; addr = 16'h0777; wd = 16'h1; be = 2'b11; rdy = 0;
    @(posedge clk);
    @(negedge clk); req = 0;
    @(posedge clk);
    @(negedge clk); #1;
    chk(bwe_n == 2'b00, "R4 both lanes before reset", bwe_n, 2'b00);
    rst_n = 0;
    #0.5;
    chk(brst_n == 0 && bwe_n == 2'b11 && rom_n && !bdoe && boe_n,
        "R11 reset in cycle", {brst_n, bwe_n, rom_n, bdoe, boe_n}, 6'b011101);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk(brst_n == 1 && cs_now() == 3'b111, "R11 idle after reset", {brst_n, cs_now()}, 4'hF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule